// File: doc/BRIEF.md
# Nibble Accumulator ALU with Carry

This block is the arithmetic core of a small nibble-serial processor. It holds a 4-bit accumulator and a one-bit carry flag. Each command it accepts applies one operation, using either a nibble read from an external 16-entry register file or a 4-bit immediate. Instruction fetch and register storage sit outside the block. The surrounding control logic reads the selected register, drives that register's value and index onto the operand inputs, and raises `cmd_valid` for one cycle together with the operation code.

Six operations are supported:

- add with carry;
- subtract with borrow, where carry low means a borrow;
- load accumulator from a register;
- load accumulator from an immediate;
- exchange the accumulator with a register;
- increment a register.

The exchange and increment operations return a nibble through a write-back port. The surrounding logic stores that nibble into the register file at the returned index. All arithmetic wraps within the nibble.

Reset is asynchronous and active low. Its release passes through a two-stage synchroniser, so the datapath leaves reset on the second rising edge after `rst_n` rises. The datapath accepts its first command on the third rising edge. Results appear on the outputs after the clock edge at which the command was sampled.

Top module: `nibble_acc_alu`

## Requirements
- R1: While reset is held, and on leaving it, `acc` is 0, `carry` is 0 and `wb_en` is 0.
- R2: Operation code 0 (add) sets {carry, acc} to `acc + reg_data + carry` as a 5-bit sum, so carry is 1 exactly when that sum exceeds 15.
- R3: Operation code 1 (subtract) sets acc to `acc - reg_data - (carry ? 0 : 1)` modulo 16. Carry becomes 0 when that difference went below zero and 1 otherwise.
- R4: Operation code 2 copies `reg_data` into acc, and code 3 copies `imm` into acc; neither changes carry.
- R5: Operation code 4 (exchange) loads `reg_data` into acc and, in the same update, presents the old acc on `wb_data` with `wb_en` high; carry is unchanged.
- R6: Operation code 5 (increment) presents `(reg_data + 1) mod 16` on `wb_data` with `wb_en` high (0xF becomes 0x0), and leaves acc and carry unchanged.
- R7: In a cycle with `cmd_valid` low, acc and carry hold their values and `wb_en` is 0 in the following cycle, whatever the other inputs are.
- R8: Operation codes 6 and 7 change neither acc nor carry and raise no write-back.
- R9: `wb_en` is high for exactly one cycle after each exchange or increment command and never otherwise, and `wb_sel` then equals the `reg_sel` sampled with that command.
- R10: A command presented on the first two rising edges after `rst_n` rises has no effect: acc and carry remain 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| cmd_valid | input | 1 | One-cycle strobe qualifying a command |
| cmd_op | input | 3 | Operation code (0 add, 1 subtract, 2 load reg, 3 load imm, 4 exchange, 5 increment, 6/7 no effect) |
| reg_sel | input | 4 | Index of the operand register, echoed on write-back |
| reg_data | input | 4 | Value of the operand register |
| imm | input | 4 | Immediate nibble for load-immediate |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry / not-borrow flag |
| wb_en | output | 1 | Write-back strobe for the register file |
| wb_sel | output | 4 | Register index to write back |
| wb_data | output | 4 | Nibble to write back |

## Verification
The result assertions are disabled until the synchronised reset has released. A command presented during the two release edges would therefore never be checked. The bench deliberately presents one there only to confirm that it is dropped. Each command is treated as a single-cycle strobe with stable operands in that cycle, and the bench drives every input on the falling edge so that operands are settled at the sampling edge. Carry has no direct load path, so the bench forces it to a chosen value through a preparatory add. It then sweeps every accumulator, operand and carry-in combination for both arithmetic operations.

// File: rtl/nacc_pkg.sv
package nacc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_LDR  = 3'd2,
    OP_LDI  = 3'd3,
    OP_XCH  = 3'd4,
    OP_INC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } nacc_op_e;
endpackage

// File: rtl/nacc_rst_sync.sv
module nacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nacc_adder.sv
module nacc_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];
endmodule

// File: rtl/nacc_exec.sv
module nacc_exec
  import nacc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    acc_q,
  input  logic            carry_q,
  input  logic [W-1:0]    opnd,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    acc_d,
  output logic            carry_d,
  output logic            wb_d,
  output logic [W-1:0]    wb_data_d
);
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout;

  // One shared adder: add, subtract (inverted operand) and increment.
  always_comb begin
    add_a   = acc_q;
    add_b   = opnd;
    add_cin = carry_q;
    unique case (nacc_op_e'(op))
      OP_SUB:  add_b = ~opnd;
      OP_INC:  begin
        add_a   = opnd;
        add_b   = '0;
        add_cin = 1'b1;
      end
      default: ;
    endcase
  end

  nacc_adder #(.W(W)) u_adder (
    .a   (add_a),
    .b   (add_b),
    .cin (add_cin),
    .sum (add_sum),
    .cout(add_cout)
  );

  always_comb begin
    acc_d     = acc_q;
    carry_d   = carry_q;
    wb_d      = 1'b0;
    wb_data_d = add_sum;
    unique case (nacc_op_e'(op))
      OP_ADD, OP_SUB: begin
        acc_d   = add_sum;
        carry_d = add_cout;
      end
      OP_LDR: acc_d = opnd;
      OP_LDI: acc_d = imm;
      OP_XCH: begin
        acc_d     = opnd;
        wb_d      = 1'b1;
        wb_data_d = acc_q;
      end
      OP_INC: wb_d = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nibble_acc_alu.sv
module nibble_acc_alu
  import nacc_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     reg_data,
  input  logic [W-1:0]     imm,
  output logic [W-1:0]     acc,
  output logic             carry,
  output logic             wb_en,
  output logic [SEL_W-1:0] wb_sel,
  output logic [W-1:0]     wb_data
);
  logic             rst_sync_n;
  logic [W-1:0]     acc_q, acc_d, wb_data_q, wb_data_d;
  logic             carry_q, carry_d, wb_d, wb_en_q;
  logic [SEL_W-1:0] wb_sel_q;
  logic             wb_load;

  nacc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  nacc_exec #(.W(W)) u_exec (
    .op       (cmd_op),
    .acc_q    (acc_q),
    .carry_q  (carry_q),
    .opnd     (reg_data),
    .imm      (imm),
    .acc_d    (acc_d),
    .carry_d  (carry_d),
    .wb_d     (wb_d),
    .wb_data_d(wb_data_d)
  );

  assign wb_load = cmd_valid & wb_d;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (cmd_valid) begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wb_en_q <= 1'b0;
    else             wb_en_q <= wb_load;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_sel_q  <= '0;
      wb_data_q <= '0;
    end else if (wb_load) begin
      wb_sel_q  <= reg_sel;
      wb_data_q <= wb_data_d;
    end
  end

  assign acc     = acc_q;
  assign carry   = carry_q;
  assign wb_en   = wb_en_q;
  assign wb_sel  = wb_sel_q;
  assign wb_data = wb_data_q;
endmodule

// File: rtl/nacc_alu_chk.sv
module nacc_alu_chk #(
  parameter int W     = 4,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [SEL_W-1:0] reg_sel,
  input logic [W-1:0]     reg_data,
  input logic [W-1:0]     imm,
  input logic [W-1:0]     acc,
  input logic             carry,
  input logic             wb_en,
  input logic [SEL_W-1:0] wb_sel,
  input logic [W-1:0]     wb_data
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc == '0 && !carry && !wb_en)); // R1

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd0) |=>
      ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(reg_data)} +
                        {{W{1'b0}}, $past(carry)}))); // R2

  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd1) |=>
      (acc == $past(acc) - $past(reg_data) - {{(W-1){1'b0}}, !$past(carry)})); // R3

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd1) |=>
      (carry == (($past(acc) > $past(reg_data)) ||
                 ($past(acc) == $past(reg_data) && $past(carry))))); // R3

  AST_LOAD_REG: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd2) |=> (acc == $past(reg_data) && $stable(carry))); // R4

  AST_LOAD_IMM: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd3) |=> (acc == $past(imm) && $stable(carry))); // R4

  AST_XCH_SWAP: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd4) |=>
      (acc == $past(reg_data) && wb_data == $past(acc) && wb_en && $stable(carry))); // R5

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op == 3'd5) |=>
      (wb_data == $past(reg_data) + 1'b1 && wb_en && $stable(acc) && $stable(carry))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !cmd_valid |=> ($stable(acc) && $stable(carry) && !wb_en)); // R7

  AST_RSV_NOP: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && cmd_op[2:1] == 2'b11) |=> ($stable(acc) && $stable(carry) && !wb_en)); // R8

  AST_WB_SOURCE: assert property (@(posedge clk) disable iff (!rst_ok)
    wb_en |-> ($past(cmd_valid) && ($past(cmd_op) == 3'd4 || $past(cmd_op) == 3'd5))); // R9

  AST_WB_INDEX: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_valid && (cmd_op == 3'd4 || cmd_op == 3'd5)) |=> (wb_sel == $past(reg_sel))); // R9

  AST_RELEASE_IDLE: assert property (@(posedge clk)
    (rst_n && !rst_ok) |=> (acc == '0 && !carry)); // R10
endmodule

bind nibble_acc_alu nacc_alu_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_ok   (rst_sync_n),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .reg_sel  (reg_sel),
  .reg_data (reg_data),
  .imm      (imm),
  .acc      (acc),
  .carry    (carry),
  .wb_en    (wb_en),
  .wb_sel   (wb_sel),
  .wb_data  (wb_data)
);

// File: tb/nibble_acc_alu_tb.sv
module nibble_acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [3:0] reg_sel, reg_data, imm;
  logic [3:0] acc, wb_sel, wb_data;
  logic       carry, wb_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] m_acc;
  logic       m_c;

  always #10 clk = ~clk;

  nibble_acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .reg_sel(reg_sel), .reg_data(reg_data), .imm(imm),
    .acc(acc), .carry(carry), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  task automatic check(input string tag, input logic ewb, input logic [3:0] ewd,
                       input logic [3:0] esel);
    n_chk++;
    if (acc !== m_acc || carry !== m_c || wb_en !== ewb ||
        (ewb && (wb_data !== ewd || wb_sel !== esel))) begin
      n_bad++;
      $display("FAIL %s: got acc=%h c=%b wb=%b wd=%h ws=%h exp acc=%h c=%b wb=%b wd=%h ws=%h",
               tag, acc, carry, wb_en, wb_data, wb_sel, m_acc, m_c, ewb, ewd, esel);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic run(input string tag, input logic [2:0] op, input logic [3:0] rd,
                     input logic [3:0] im, input logic [3:0] rs);
    logic       ewb = 1'b0;
    logic [3:0] ewd = 4'h0;
    int         s;
    case (op)
      3'd0: begin s = int'(m_acc) + int'(rd) + int'(m_c);
                  m_acc = 4'(s % 16); m_c = (s > 15); end
      3'd1: begin s = int'(m_acc) - int'(rd) - (m_c ? 0 : 1);
                  m_acc = 4'((s + 32) % 16); m_c = (s >= 0); end
      3'd2: m_acc = rd;
      3'd3: m_acc = im;
      3'd4: begin ewb = 1'b1; ewd = m_acc; m_acc = rd; end
      3'd5: begin ewb = 1'b1; ewd = 4'((int'(rd) + 1) % 16); end
      default: ;
    endcase
    cmd_valid = 1'b1; cmd_op = op; reg_data = rd; imm = im; reg_sel = rs;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(tag, ewb, ewd, rs);
  endtask

  task automatic set_carry(input logic c);
    if (c) begin run("R2 prep", 3'd3, 4'h0, 4'hF, 4'h0); run("R2 prep", 3'd0, 4'h1, 4'h0, 4'h0); end
    else   begin run("R2 prep", 3'd3, 4'h0, 4'h0, 4'h0); run("R2 prep", 3'd0, 4'h0, 4'h0, 4'h0); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    reg_sel = 4'h0; reg_data = 4'h0; imm = 4'h0;
    m_acc = 4'h0; m_c = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 4'h0, 4'h0);

    // R10: a load presented across the two release edges is dropped
    rst_n = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd3; imm = 4'h9;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 release", 1'b0, 4'h0, 4'h0);
    check("R1 after release", 1'b0, 4'h0, 4'h0);

    // R2 / R3 exhaustive sweeps over acc, operand and carry-in
    for (int op = 0; op < 2; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            set_carry(ci[0]);
            run("R4 setup", 3'd3, 4'h0, a[3:0], 4'h0);
            run(op == 0 ? "R2 add" : "R3 sub", op[2:0], b[3:0], 4'h0, 4'h0);
          end

    // R4 loads keep carry, both carry values
    for (int ci = 0; ci < 2; ci++) begin
      set_carry(ci[0]);
      for (int v = 0; v < 16; v++) begin
        run("R4 ldr", 3'd2, v[3:0], ~v[3:0], 4'h3);
        run("R4 ldi", 3'd3, ~v[3:0], v[3:0], 4'h5);
      end
    end

    // R5 exchange and R9 index echo
    set_carry(1'b1);
    for (int v = 0; v < 16; v++)
      run("R5 xch", 3'd4, v[3:0], 4'h0, 4'(15 - v));

    // R6 increment including wrap, R9 index echo
    for (int v = 0; v < 16; v++)
      run("R6 inc", 3'd5, v[3:0], 4'h0, v[3:0]);

    // R7 idle cycles with busy inputs
    run("R4 ldi", 3'd3, 4'h0, 4'hA, 4'h0);
    for (int k = 0; k < 8; k++) begin
      cmd_op = k[2:0]; reg_data = 4'(k * 3); imm = 4'(k + 7); reg_sel = k[3:0];
      @(negedge clk);
      check("R7 idle", 1'b0, 4'h0, 4'h0);
    end

    // R8 reserved codes
    for (int ci = 0; ci < 2; ci++) begin
      set_carry(ci[0]);
      run("R4 ldi", 3'd3, 4'h0, 4'h6, 4'h0);
      run("R8 rsv6", 3'd6, 4'hF, 4'hF, 4'h2);
      run("R8 rsv7", 3'd7, 4'h1, 4'h3, 4'h4);
    end

    // R9 write-back lasts a single cycle
    run("R9 inc", 3'd5, 4'h7, 4'h0, 4'hC);
    @(negedge clk);
    check("R9 wb drop", 1'b0, 4'h0, 4'h0);

    // R1 reset mid-run
    run("R2 add", 3'd0, 4'hE, 4'h0, 4'h0);
    rst_n = 1'b0;
    m_acc = 4'h0; m_c = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 1'b0, 4'h0, 4'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule